// File: doc/BRIEF.md
# Banked Memory Address Mapper

This block sits between the address bus of an 8-bit microprocessor and its memory chips. It turns each 16-bit CPU address into one of three chip selects (RAM, ROM, device request) and a 17-bit physical RAM address. The lowest 16K of the CPU space is a movable window. A small bank register supplies the upper three physical address bits for accesses inside it, so software can reach any of eight 16K pages of a 128K RAM. Above the window there is fixed RAM, then a 4K device region served by an IO coprocessor, then an upper region. A configuration input decides whether that upper region is ROM or ordinary writable RAM.

Outside the window the physical address is the CPU address with a zero placed above it. As a result, some window pages share storage with fixed RAM or with the upper region. The coprocessor loads the bank register with a strobe after the CPU has written to device space. The new page applies to accesses from the following clock cycle onward.

Top module: `bank_addr_mapper`

## Requirements
- R1: For CPU addresses 0x0000–0x3FFF, phys_addr[16:14] equals the stored bank value and phys_addr[13:0] equals cpu_addr[13:0].
- R2: For CPU addresses 0x4000–0xFFFF, phys_addr[15:0] equals cpu_addr and phys_addr[16] is 0.
- R3: With cyc_valid high, addresses 0x0000–0x9FFF assert ram_sel only, and addresses 0xA000–0xAFFF assert io_req only.
- R4: With cyc_valid high, addresses 0xB000–0xFFFF assert rom_sel only when rom_en is 1, and ram_sel only when rom_en is 0. In the second case the address maps to physical 0x0B000–0x0FFFF and may be written.
- R5: While rst_n is low, and after it is released, the bank value is 0 until the first load.
- R6: A rising clock edge with bank_wr high stores bank_data[2:0]. The new value drives phys_addr from the cycle after the strobe. During the strobe cycle the old value still applies. bank_data[3] has no effect on any output.
- R7: With bank 2 stored, window offsets 0x0000–0x1FFF give physical 0x08000–0x09FFF, which is the same physical address as CPU 0x8000–0x9FFF. Offsets 0x2000–0x3FFF give 0x0A000–0x0BFFF.
- R8: At most one of ram_sel, rom_sel and io_req is high, and all three are low while cyc_valid is low.
- R9: rom_wr_flag is high exactly when rom_sel is high and cpu_rnw is 0 (a write).
- R10: With bank_wr low, the bank value is unchanged whatever bank_data carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the bank value |
| cpu_addr | input | 16 | CPU address |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| cyc_valid | input | 1 | Address on the bus is a valid access |
| rom_en | input | 1 | 1 = upper region is ROM, 0 = upper region is RAM |
| bank_wr | input | 1 | Bank register load strobe |
| bank_data | input | 4 | Bank value; bits 2:0 are used |
| ram_sel | output | 1 | RAM chip select |
| rom_sel | output | 1 | ROM chip select |
| io_req | output | 1 | Device-space request |
| rom_wr_flag | output | 1 | Write attempted while the ROM is selected |
| phys_addr | output | 17 | Physical RAM address |

## Verification
The bench sweeps addresses across all four regions for every bank value, with both rom_en settings, reads and writes, and valid and idle cycles. This catches an off-by-one boundary at 0x3FFF/0x4000, 0x9FFF/0xA000 or 0xAFFF/0xB000: such a design would assert the wrong select or bank an address it should pass through. It checks the strobe cycle itself, where a design that bypasses the register would use the new page one cycle early. It also drives a random bank_data[3] and random data between strobes, which exposes a register that is four bits wide or that loads without the strobe. An explicit bank 2 check confirms the alias onto fixed RAM. A mapper that set bit 16 outside the window would fail that check.

// File: rtl/bam_pkg.sv
package bam_pkg;
   typedef enum logic [1:0] {
      RGN_WIN = 2'd0,
      RGN_FIX = 2'd1,
      RGN_DEV = 2'd2,
      RGN_TOP = 2'd3
   } region_e;
endpackage

// File: rtl/bam_region_decode.sv
module bam_region_decode
   import bam_pkg::*;
#(
   parameter int CPU_AW   = 16,
   parameter int WIN_END  = 'h4000,
   parameter int DEV_BASE = 'hA000,
   parameter int DEV_END  = 'hB000
) (
   input  logic [CPU_AW-1:0] addr,
   output region_e           region
);
   localparam int SPACE = 1 << CPU_AW;

   if (!(WIN_END > 0 && WIN_END < DEV_BASE && DEV_BASE < DEV_END && DEV_END <= SPACE))
   begin : g_bad_map
      $error("bam_region_decode: region boundaries out of order");
   end

   localparam logic [CPU_AW-1:0] W_END = CPU_AW'(WIN_END);
   localparam logic [CPU_AW-1:0] D_LO  = CPU_AW'(DEV_BASE);
   localparam logic [CPU_AW-1:0] D_HI  = CPU_AW'(DEV_END - 1);

   always_comb begin
      if (addr < W_END)                       region = RGN_WIN;
      else if (addr < D_LO)                   region = RGN_FIX;
      else if (addr <= D_HI)                  region = RGN_DEV;
      else                                    region = RGN_TOP;
   end
endmodule

// File: rtl/bam_bank_reg.sv
module bam_bank_reg #(
   parameter int DATA_W = 4,
   parameter int BANK_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic [BANK_W-1:0] bank
);
   if (BANK_W < 1 || DATA_W < BANK_W) begin : g_bad_w
      $error("bam_bank_reg: DATA_W must be at least BANK_W");
   end

   if (DATA_W > BANK_W) begin : g_spare
      logic spare_unused;
      assign spare_unused = ^din[DATA_W-1:BANK_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bank <= '0;
      else if (load)  bank <= din[BANK_W-1:0];
   end

   assert_bank_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(load) |-> bank == $past(din[BANK_W-1:0]));

   assert_bank_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load) |-> $stable(bank));
endmodule

// File: rtl/bam_phys_addr.sv
module bam_phys_addr #(
   parameter int CPU_AW   = 16,
   parameter int WIN_BITS = 14,
   parameter int BANK_W   = 3
) (
   input  logic [CPU_AW-1:0]          addr,
   input  logic                       in_win,
   input  logic [BANK_W-1:0]          bank,
   output logic [BANK_W+WIN_BITS-1:0] phys
);
   localparam int PHYS_AW = BANK_W + WIN_BITS;
   localparam int PAD     = PHYS_AW - CPU_AW;

   if (WIN_BITS >= CPU_AW || PAD < 0) begin : g_bad_w
      $error("bam_phys_addr: physical space smaller than CPU space");
   end

   logic [PHYS_AW-1:0] pass;
   if (PAD > 0) begin : g_pad
      assign pass = {{PAD{1'b0}}, addr};
   end else begin : g_flat
      assign pass = addr;
   end

   always_comb begin
      if (in_win) phys = {bank, addr[WIN_BITS-1:0]};
      else        phys = pass;
   end
endmodule

// File: rtl/bank_addr_mapper.sv
module bank_addr_mapper
   import bam_pkg::*;
#(
   parameter int CPU_AW   = 16,
   parameter int WIN_BITS = 14,
   parameter int BANK_W   = 3,
   parameter int DATA_W   = 4,
   parameter int DEV_BASE = 'hA000,
   parameter int DEV_END  = 'hB000
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [CPU_AW-1:0]          cpu_addr,
   input  logic                       cpu_rnw,
   input  logic                       cyc_valid,
   input  logic                       rom_en,
   input  logic                       bank_wr,
   input  logic [DATA_W-1:0]          bank_data,
   output logic                       ram_sel,
   output logic                       rom_sel,
   output logic                       io_req,
   output logic                       rom_wr_flag,
   output logic [BANK_W+WIN_BITS-1:0] phys_addr
);
   localparam int PHYS_AW = BANK_W + WIN_BITS;
   localparam int WIN_END = 1 << WIN_BITS;

   region_e            region;
   logic [BANK_W-1:0]  bank_q;

   bam_region_decode #(
      .CPU_AW(CPU_AW), .WIN_END(WIN_END),
      .DEV_BASE(DEV_BASE), .DEV_END(DEV_END)
   ) i_decode (
      .addr(cpu_addr), .region(region)
   );

   bam_bank_reg #(.DATA_W(DATA_W), .BANK_W(BANK_W)) i_bank (
      .clk(clk), .rst_n(rst_n), .load(bank_wr), .din(bank_data), .bank(bank_q)
   );

   bam_phys_addr #(.CPU_AW(CPU_AW), .WIN_BITS(WIN_BITS), .BANK_W(BANK_W)) i_phys (
      .addr(cpu_addr), .in_win(region == RGN_WIN), .bank(bank_q), .phys(phys_addr)
   );

   always_comb begin
      ram_sel = 1'b0;
      rom_sel = 1'b0;
      io_req  = 1'b0;
      if (cyc_valid) begin
         unique case (region)
            RGN_WIN, RGN_FIX: ram_sel = 1'b1;
            RGN_DEV:          io_req  = 1'b1;
            RGN_TOP:          if (rom_en) rom_sel = 1'b1; else ram_sel = 1'b1;
         endcase
      end
      rom_wr_flag = rom_sel & ~cpu_rnw;
   end

   assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ram_sel, rom_sel, io_req}));

   assert_sel_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_valid |-> !(ram_sel || rom_sel || io_req));

   assert_win_bank_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr < CPU_AW'(WIN_END)) |-> phys_addr[PHYS_AW-1:WIN_BITS] == bank_q);

   assert_pass_thru_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr >= CPU_AW'(WIN_END)) |-> phys_addr == PHYS_AW'(cpu_addr));

   assert_dev_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      io_req |-> (cpu_addr >= CPU_AW'(DEV_BASE) && cpu_addr < CPU_AW'(DEV_END)));

   assert_rom_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rom_sel |-> rom_en);

   assert_rom_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rom_wr_flag |-> (rom_sel && !cpu_rnw));
endmodule

// File: tb/test_bank_addr_mapper.sv
module test_bank_addr_mapper;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_rnw = 1'b1;
   logic        cyc_valid = 1'b0;
   logic        rom_en = 1'b1;
   logic        bank_wr = 1'b0;
   logic [3:0]  bank_data = '0;
   logic        ram_sel, rom_sel, io_req, rom_wr_flag;
   logic [16:0] phys_addr;

   int n_vec = 0;
   int n_bad = 0;
   int exp_bank = 0;
   bit finished = 0;

   always #(CLK_P/2) clk = ~clk;

   bank_addr_mapper i_bank_addr_mapper (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rnw(cpu_rnw),
      .cyc_valid(cyc_valid), .rom_en(rom_en), .bank_wr(bank_wr),
      .bank_data(bank_data), .ram_sel(ram_sel), .rom_sel(rom_sel),
      .io_req(io_req), .rom_wr_flag(rom_wr_flag), .phys_addr(phys_addr)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s addr=%h act=%h exp=%h", tag, cpu_addr, act, exp);
      end
   endtask

   // Drive one access away from the clock edge and compare every output.
   task automatic access(input int a, input bit rnw, input bit valid, input bit ren);
      int exp_phys;
      bit e_ram, e_rom, e_io;
      string tag;
      @(negedge clk);
      cpu_addr  = 16'(a);
      cpu_rnw   = rnw;
      cyc_valid = valid;
      rom_en    = ren;
      bank_data = 4'($urandom);   // R10: garbage with no strobe
      #2;
      if (a < 'h4000) begin
         exp_phys = exp_bank * 'h4000 + a; tag = "R1";
      end else begin
         exp_phys = a; tag = "R2";
      end
      e_ram = valid && (a < 'hA000 || (a >= 'hB000 && !ren));
      e_io  = valid && a >= 'hA000 && a < 'hB000;
      e_rom = valid && a >= 'hB000 && ren;
      check(tag, 32'(phys_addr), 32'(exp_phys));
      check(valid ? (a >= 'hB000 ? "R4" : "R3") : "R8",
            {29'd0, ram_sel, rom_sel, io_req}, {29'd0, e_ram, e_rom, e_io});
      check("R9", 32'(rom_wr_flag), 32'(e_rom && !rnw));
   endtask

   task automatic load_bank(input int b);
      @(negedge clk);
      cpu_addr  = 16'h0123;
      cyc_valid = 1'b1;
      bank_wr   = 1'b1;
      bank_data = {1'($urandom), 3'(b)};   // R6: bit 3 random
      #2;
      check("R6 strobe cycle uses old bank", 32'(phys_addr), 32'(exp_bank * 'h4000 + 'h123));
      @(negedge clk);
      bank_wr = 1'b0;
      exp_bank = b;
      #2;
      check("R6 next cycle uses new bank", 32'(phys_addr), 32'(b * 'h4000 + 'h123));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      cpu_addr = 16'h1234;
      #1;
      check("R5 phys in reset", 32'(phys_addr), 32'h01234);
      rst_n = 1'b1;
      access('h1234, 1'b1, 1'b1, 1'b1);   // R5 after release

      for (int b = 7; b >= 0; b--) begin
         load_bank(b);
         for (int i = 0; i < 256; i++) begin
            for (int m = 0; m < 8; m++) begin
               int a = i * 256 + ((i * 37 + m * 11) & 8'hff);
               if (i == 'h3F && m == 0) a = 'h3FFF;
               if (i == 'h40 && m == 0) a = 'h4000;
               if (i == 'h9F && m == 0) a = 'h9FFF;
               if (i == 'hA0 && m == 0) a = 'hA000;
               if (i == 'hAF && m == 0) a = 'hAFFF;
               if (i == 'hB0 && m == 0) a = 'hB000;
               access(a, m[0], m[1] | m[2], m[2]);
            end
         end
      end

      load_bank(2);
      access('h0000, 1'b0, 1'b1, 1'b1);
      check("R7 alias low", 32'(phys_addr), 32'h08000);
      access('h1FFF, 1'b0, 1'b1, 1'b1);
      check("R7 alias top", 32'(phys_addr), 32'h09FFF);
      access('h2000, 1'b0, 1'b1, 1'b1);
      check("R7 upper half", 32'(phys_addr), 32'h0A000);
      access('h8000, 1'b0, 1'b1, 1'b1);
      check("R7 fixed twin", 32'(phys_addr), 32'h08000);
      access('hC000, 1'b0, 1'b1, 1'b0);
      check("R4 ram-only write", {31'd0, ram_sel}, 32'd1);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog act=timeout exp=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule